// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing half of a small serial nonvolatile memory. It oversamples the two-wire clock and data lines with a fast system clock and recognises START and STOP conditions. It shifts in the device-select byte, the word address and any data bytes, and it answers each byte it accepts by pulling the data line low during the ninth clock pulse. The data line is open-drain. The block only ever pulls it low or lets it float high.

A write sends the device byte with a low read/write bit, then a word address, then any number of data bytes. The bytes land in an eight-slot page buffer, indexed by the word address modulo eight. A long burst therefore overwrites its oldest bytes and keeps only the last eight. A STOP commits the buffer to a register-array memory inside the aligned 8-byte page and starts a programming interval counted in system clocks. During that interval the slave stays silent. A read sends the device byte with a high read/write bit. It returns bytes from the current address, most significant bit first, and advances the address each time the master acknowledges. The usual random read sets the address with a write header and then issues a repeated START.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the block does not pull the data line low, and it waits for a START.
- R2: The block acknowledges the first byte after a START only when its upper four bits equal `DEV_CODE` (default 4'b1010). Bit 0 of that byte selects read (1) or write (0). On a mismatch it stays silent for the rest of that byte and ignores every later byte until the next START.
- R3: In a write, the block pulls the data line low for the whole ninth clock pulse after the word address and after every data byte.
- R4: On STOP, the buffered bytes are stored at consecutive addresses starting at the word address. The low three address bits wrap inside the aligned 8-byte page.
- R5: When a write carries more than eight data bytes, only the last eight are stored. Each extra byte replaces the oldest buffered byte.
- R6: For `PROG_CYCLES` system clocks after a commit, the block acknowledges no byte at all, including its own device byte. After that interval it acknowledges normally again.
- R7: A read returns the byte at the current address, MSB first. The address advances by one after each byte the master acknowledges, so successive bytes come from consecutive addresses.
- R8: When the master leaves the acknowledge bit high after a read byte, the block releases the data line, stops transmitting and waits for a START.
- R9: A STOP that arrives before any data byte has been acknowledged, including a STOP in the middle of a byte, leaves the memory unchanged and starts no programming interval.
- R10: A repeated START discards the data bytes buffered so far in a write, so nothing is committed. A read that follows returns data from the word address just sent.
- R11: The block changes its drive on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
The bench targets the page-buffer arithmetic with a write that starts two bytes before a page end, and with a ten-byte burst. A design that wrapped across pages, or kept the first eight bytes instead of the last eight, would read back the wrong bytes at the page base. It also issues a device byte straight after a commit. A slave that ignored its programming interval would acknowledge that byte. A STOP partway through a data byte and a repeated START after a buffered byte both check that nothing is committed: a design that committed on any STOP would corrupt the target location or become busy. Finally, every bit the slave transmits is sampled at both ends of the clock-high phase, and the line is checked to be released after a master non-acknowledge. This catches a slave that switches its output late or keeps driving after the read ends.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  // Bus-side phases of the slave
  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for START
    ST_RX,    // shifting a byte in
    ST_ACK,   // holding the line low for the ninth pulse
    ST_TX,    // shifting a byte out
    ST_MACK   // master's acknowledge slot after a sent byte
  } bus_state_e;

  // Meaning of the byte being received
  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_DATA,
    K_READ
  } byte_kind_e;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;

  // Synchronizer chains reset to the idle (high) bus level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[STAGES-2:0], sda_i};
      scl_prev <= scl_sync[STAGES-1];
      sda_prev <= sda_sync[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sync[STAGES-1];
  assign sda_lvl   = sda_sync[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // Data edges while the clock stays high mark bus conditions
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twi_wr_buffer.sv
module twi_wr_buffer #(
  parameter int IDX_W = 3,
  parameter int DW    = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear,
  input  logic                                load,
  input  logic [IDX_W-1:0]                    load_idx,
  input  logic                                push,
  input  logic [DW-1:0]                       push_data,
  output logic [(1<<IDX_W)-1:0][DW-1:0]       slot_data,
  output logic [(1<<IDX_W)-1:0]               slot_vld
);
  localparam int SLOTS = 1 << IDX_W;

  logic [IDX_W-1:0] wr_ptr, wr_ptr_n;
  logic [SLOTS-1:0] vld_n;

  always_comb begin
    wr_ptr_n = wr_ptr;
    vld_n    = slot_vld;
    if (load) wr_ptr_n = load_idx;
    else if (push) wr_ptr_n = wr_ptr + IDX_W'(1);
    if (clear) vld_n = '0;
    else if (push) vld_n[wr_ptr] = 1'b1;   // R5: slot reused in arrival order
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      slot_vld <= '0;
    end else begin
      wr_ptr   <= wr_ptr_n;
      slot_vld <= vld_n;
    end
  end

  // Data slots carry no reset; validity lives in slot_vld
  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (push && wr_ptr == IDX_W'(s)) slot_data[s] <= push_data;
    end
  end
endmodule

// File: rtl/twi_prog_timer.sv
module twi_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start) cnt_n = CW'(CYCLES);
    else if (cnt_q != '0) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eep_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         MEM_AW      = 7,
  parameter int         PAGE_AW     = 3,
  parameter int         PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int PG_W       = MEM_AW - PAGE_AW;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  twi_line_cond #(.STAGES(2)) u_line (
    .clk(clk), .rst_n(rst_n_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  bus_state_e            state, state_n;
  byte_kind_e            kind, kind_n;
  logic [3:0]            cnt, cnt_n;
  logic [7:0]            shreg, shreg_n;
  logic                  rd_mode, rd_mode_n;
  logic [MEM_AW-1:0]     addr, addr_n;
  logic [PG_W-1:0]       wr_page, wr_page_n;
  logic                  pull_n;
  logic                  buf_clear, buf_load, buf_push, commit, busy, byte_ack;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_vld;
  logic [7:0]            mem_q [MEM_BYTES];
  logic [7:0]            tx_byte;

  twi_wr_buffer #(.IDX_W(PAGE_AW), .DW(8)) u_buf (
    .clk(clk), .rst_n(rst_n_i), .clear(buf_clear), .load(buf_load),
    .load_idx(shreg[PAGE_AW-1:0]), .push(buf_push), .push_data(shreg),
    .slot_data(buf_data), .slot_vld(buf_vld)
  );

  twi_prog_timer #(.CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n_i), .start(commit), .busy(busy)
  );

  // R2, R6: accept a byte only when idle internally and, for the device byte, on a code match
  assign byte_ack = !busy && ((kind != K_DEV) || (shreg[7:4] == DEV_CODE));

  always_comb begin
    state_n   = state;
    kind_n    = kind;
    cnt_n     = cnt;
    shreg_n   = shreg;
    rd_mode_n = rd_mode;
    addr_n    = addr;
    wr_page_n = wr_page;
    buf_clear = 1'b0;
    buf_load  = 1'b0;
    buf_push  = 1'b0;
    commit    = 1'b0;
    if (start_det) begin
      // R10: a (repeated) START drops anything buffered
      state_n   = ST_RX;
      kind_n    = K_DEV;
      cnt_n     = '0;
      buf_clear = 1'b1;
    end else if (stop_det) begin
      // R4, R9: commit only if a data byte was accepted
      state_n   = ST_IDLE;
      cnt_n     = '0;
      commit    = (kind == K_DATA) && (|buf_vld) && !busy;
      buf_clear = 1'b1;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg_n = {shreg[6:0], sda_lvl};
            cnt_n   = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            if (byte_ack) begin
              state_n = ST_ACK;
              case (kind)
                K_DEV:   rd_mode_n = shreg[0];
                K_WADDR: begin
                  addr_n    = shreg[MEM_AW-1:0];
                  wr_page_n = shreg[MEM_AW-1:PAGE_AW];
                  buf_load  = 1'b1;
                end
                K_DATA:  buf_push = 1'b1;
                default: ;
              endcase
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind == K_DEV && rd_mode) begin
              state_n = ST_TX;
              kind_n  = K_READ;
            end else begin
              state_n = ST_RX;
              kind_n  = (kind == K_DEV) ? K_WADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              state_n = ST_MACK;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_lvl) state_n = ST_IDLE;           // R8
            else addr_n = addr + MEM_AW'(1);          // R7
          end else if (scl_fall) begin
            state_n = ST_TX;
            cnt_n   = '0;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // Output drive is registered from the next state (R11: moves only after a clock fall)
  assign tx_byte = mem_q[addr_n];
  always_comb begin
    pull_n = 1'b0;
    if (state_n == ST_ACK) pull_n = 1'b1;
    else if (state_n == ST_TX) pull_n = ~tx_byte[3'd7 - cnt_n[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state      <= ST_IDLE;
      kind       <= K_DEV;
      cnt        <= '0;
      shreg      <= '0;
      rd_mode    <= 1'b0;
      addr       <= '0;
      wr_page    <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      state      <= state_n;
      kind       <= kind_n;
      cnt        <= cnt_n;
      shreg      <= shreg_n;
      rd_mode    <= rd_mode_n;
      addr       <= addr_n;
      wr_page    <= wr_page_n;
      sda_pull_o <= pull_n;
    end
  end

  // Storage array: each valid slot lands at its offset in the selected page
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int s = 0; s < PAGE_BYTES; s++) begin
        if (buf_vld[s]) mem_q[{wr_page, PAGE_AW'(s)}] <= buf_data[s];
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk
  import twi_eep_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input logic       clk,
  input logic       rst_n,
  input bus_state_e state,
  input byte_kind_e kind,
  input logic [7:0] shreg,
  input logic       busy,
  input logic       commit,
  input logic       scl_lvl,
  input logic       sda_lvl,
  input logic       scl_rise,
  input logic       sda_pull
);
  p_code_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && kind == K_DEV) |-> (shreg[7:4] == DEV_CODE));

  p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK && scl_rise && sda_lvl) |=> (state == ST_IDLE && !sda_pull));

  p_hold_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_lvl) |-> $stable(sda_pull));
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.DEV_CODE(DEV_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .state(state), .kind(kind), .shreg(shreg),
  .busy(busy), .commit(commit), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
  .scl_rise(scl_rise), .sda_pull(sda_pull_o)
);

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
  localparam int Q    = 10;     // quarter bus bit in system clocks
  localparam int PROG = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  typedef logic [7:0] bytes_t [16];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  twi_eeprom_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic early;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(1);
      early = sda_line;
      tick(2 * Q - 2);
      d[i] = sda_line;
      check("R11 bit stable during clock high", {31'd0, d[i]}, {31'd0, early});
      tick(1);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // Full write: device byte, word address, data, STOP
  task automatic wr_txn(input logic [7:0] a, input bytes_t d, input int n, input bit wait_prog);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); check("R2 device byte acknowledged", {31'd0, ack}, 32'd1);
    send_byte(a, ack);     check("R3 word address acknowledged", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); check("R3 data byte acknowledged", {31'd0, ack}, 32'd1);
    end
    bus_stop();
    if (wait_prog) tick(PROG + 50);
  endtask

  // Random read: address header, repeated START, n bytes, last one not acknowledged
  task automatic rd_txn(input logic [7:0] a, input int n, output bytes_t d);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); check("R2 device byte acknowledged", {31'd0, ack}, 32'd1);
    send_byte(a, ack);     check("R3 word address acknowledged", {31'd0, ack}, 32'd1);
    bus_start();
    send_byte(8'hA1, ack); check("R7 read device byte acknowledged", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, d[i]);
    check("R8 line released after master NACK", {31'd0, sda_pull}, 32'd0);
    tick(Q);
    check("R8 still released in the low phase", {31'd0, sda_pull}, 32'd0);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 data line released after reset", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic t_bad_code();
    logic ack;
    bus_start();
    send_byte(8'h20, ack); check("R2 foreign device code refused", {31'd0, ack}, 32'd0);
    send_byte(8'hA0, ack); check("R2 bytes ignored until next START", {31'd0, ack}, 32'd0);
    bus_stop();
  endtask

  task automatic t_write_read();
    bytes_t w, r;
    w = '{default: 8'h00};
    w[0] = 8'h5A; w[1] = 8'hC3; w[2] = 8'h01;
    wr_txn(8'h10, w, 3, 1'b1);
    rd_txn(8'h10, 3, r);
    for (int i = 0; i < 3; i++)
      check("R4 R7 sequential readback", {24'd0, r[i]}, {24'd0, w[i]});
  endtask

  task automatic t_page_wrap();
    bytes_t w, r;
    w = '{default: 8'h00};
    w[0] = 8'hC1; w[1] = 8'hC2; w[2] = 8'hC3; w[3] = 8'hC4;
    wr_txn(8'h1E, w, 4, 1'b1);
    rd_txn(8'h1E, 2, r);
    check("R4 page end first byte", {24'd0, r[0]}, 32'hC1);
    check("R4 page end second byte", {24'd0, r[1]}, 32'hC2);
    rd_txn(8'h18, 2, r);
    check("R4 wrapped to page base", {24'd0, r[0]}, 32'hC3);
    check("R4 wrapped second byte", {24'd0, r[1]}, 32'hC4);
  endtask

  task automatic t_overwrite();
    bytes_t w, r;
    w = '{default: 8'h00};
    for (int i = 0; i < 10; i++) w[i] = 8'(8'h80 + i);
    wr_txn(8'h30, w, 10, 1'b1);
    rd_txn(8'h30, 8, r);
    check("R5 ninth byte replaced oldest", {24'd0, r[0]}, 32'h88);
    check("R5 tenth byte replaced next", {24'd0, r[1]}, 32'h89);
    for (int i = 2; i < 8; i++)
      check("R5 remaining bytes kept", {24'd0, r[i]}, 32'h80 + i);
  endtask

  task automatic t_busy();
    bytes_t w;
    logic ack;
    w = '{default: 8'h00};
    w[0] = 8'h42;
    wr_txn(8'h40, w, 1, 1'b0);
    bus_start();
    send_byte(8'hA0, ack); check("R6 device byte refused while programming", {31'd0, ack}, 32'd0);
    bus_stop();
    tick(PROG + 50);
    bus_start();
    send_byte(8'hA0, ack); check("R6 acknowledged after programming", {31'd0, ack}, 32'd1);
    bus_stop();
  endtask

  task automatic t_abort();
    bytes_t w, r;
    logic ack;
    w = '{default: 8'h00};
    w[0] = 8'h11;
    wr_txn(8'h50, w, 1, 1'b1);
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h50, ack);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack); check("R9 no programming after aborted write", {31'd0, ack}, 32'd1);
    bus_stop();
    rd_txn(8'h50, 1, r);
    check("R9 memory unchanged by aborted write", {24'd0, r[0]}, 32'h11);
  endtask

  task automatic t_restart();
    bytes_t w, r;
    logic ack;
    logic [7:0] d;
    w = '{default: 8'h00};
    w[0] = 8'h33;
    wr_txn(8'h60, w, 1, 1'b1);
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h60, ack);
    send_byte(8'h77, ack); check("R3 data byte acknowledged", {31'd0, ack}, 32'd1);
    bus_start();
    send_byte(8'hA1, ack); check("R10 read after repeated START", {31'd0, ack}, 32'd1);
    recv_byte(1'b0, d);
    check("R10 read from word address, old data", {24'd0, d}, 32'h33);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack); check("R10 no commit after repeated START", {31'd0, ack}, 32'd1);
    bus_stop();
    rd_txn(8'h60, 1, r);
    check("R10 buffered byte discarded", {24'd0, r[0]}, 32'h33);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_bad_code();
    t_write_read();
    t_page_wrap();
    t_overwrite();
    t_busy();
    t_abort();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule